// File: doc/BRIEF.md
# Pulse Width and Period Capture Timer

This block times an external digital waveform with a 32-bit free-running count. It can report two things: how long the waveform stays in its first phase after a chosen start edge, and how long one full cycle lasts. The input pin is asynchronous. It passes through a two-stage synchronizer and then a one-cycle edge detector. A polarity control picks whether a falling or a rising edge starts each measurement. The opposite edge copies the running count into the width register. The next start edge copies it into the period register and restarts the count at 1 on that same clock, so consecutive periods are measured with no gap between them.

Software uses a small register port. It writes the control fields: run enable, start polarity, interrupt source and interrupt enable. It reads back the captured width, the captured period, the live count and two sticky status flags, and clears those flags by writing ones to them. If the count reaches all-ones, the block stops itself and marks the overflow.

Top module: `pulse_capture_timer`

## Requirements
- R1: A start edge seen while enabled and idle loads the count with 1. The count then rises by one on every clock, so a phase lasting N clocks at the pin is captured as N.
- R2: With start-on-rise (control bit 1) clear, a falling edge starts the measurement. The next rising edge copies the count into the width register (address 2). The following falling edge copies it into the period register (address 3) and reloads the count with 1 on the same clock.
- R3: With start-on-rise set, the edge roles swap: a rising edge starts, a falling edge captures width, and the next rising edge captures period.
- R4: With irq-on-period (control bit 2) set, the interrupt flag (status bit 0) is set on every period capture. Each event appears at the irq output three clocks after the pin changes.
- R5: With irq-on-period clear, the interrupt flag is set on every width capture with the same three-clock latency. The period register reads 0 after reset until the first period capture, so the first interrupt carries a period of 0.
- R6: When the count equals all-ones, the count stops there, the enable bit (control bit 0) clears, and the overflow flag (status bit 1) sets. The interrupt flag also sets, but only if irq-enable (control bit 3) is 1.
- R7: Both status flags stay set until a write to address 1 with a 1 in that flag's bit position. If a set event and such a clear land on the same clock, the flag stays set.
- R8: While the enable bit is 0, the count, width and period registers hold their values whatever the pin does. After re-enabling, the count stays unchanged until the next start edge.
- R9: The irq output is high only while the interrupt flag and irq-enable are both 1. A flag set while interrupts are off appears at irq as soon as irq-enable is written to 1.
- R10: The register map is: address 0 control, address 1 status, address 2 width, address 3 period, address 4 count. Any other address reads 0. All registers read 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all state |
| rstN | input | 1 | Active-low reset |
| pinIn | input | 1 | Asynchronous waveform to be measured |
| wrEn | input | 1 | Register write strobe, one clock per write |
| regAddr | input | 3 | Register address for reads and writes |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for regAddr, combinational |
| irq | output | 1 | Interrupt request, level |

## Verification
The assertions assume that reset is applied and released cleanly. They also assume that the status flags change only through capture and overflow events or through writes to address 1. The sticky and set-wins properties rely on that. The edge logic further assumes every pin level lasts at least two clocks, or the synchronizer can lose a pulse. The stimulus holds every phase for at least five clocks, moves the pin and the register port only on falling clock edges, and keeps the pin quiet across reset. It also shrinks the count width so that saturation is reached within about a thousand clocks.

// File: rtl/pct_pkg.sv
package pct_pkg;

  // Per-cycle commands from the sequencer to the counting datapath
  typedef struct packed {
    logic loadOne;    // restart the count at 1
    logic incr;       // advance the count by one (saturating)
    logic capWidth;   // copy count into the width register
    logic capPeriod;  // copy count into the period register
    logic overflow;   // count reached all-ones this cycle
  } strobe_t;

  typedef enum logic [1:0] {
    PH_IDLE,    // waiting for a start edge
    PH_FIRST,   // counting the first phase, waiting for the opposite edge
    PH_SECOND   // counting the rest of the cycle, waiting for the next start edge
  } phase_t;

endpackage

// File: rtl/pct_datapath.sv
module pct_datapath
  import pct_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pinIn,
  input  strobe_t          strb,
  output logic             riseEdge,
  output logic             fallEdge,
  output logic             atMax,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] width,
  output logic [CNT_W-1:0] period
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   prevQ;
  logic                   sampled;

  // Metastability chain, then one extra flop for edge comparison
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= '0;
      prevQ <= 1'b0;
    end else begin
      syncQ <= {syncQ[SYNC_STAGES-2:0], pinIn};
      prevQ <= syncQ[SYNC_STAGES-1];
    end
  end

  assign sampled  = syncQ[SYNC_STAGES-1];
  assign riseEdge = sampled & ~prevQ;
  assign fallEdge = ~sampled & prevQ;
  assign atMax    = (count == CNT_MAX);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else if (strb.loadOne) begin
      count <= CNT_ONE;
    end else if (strb.incr && !atMax) begin
      count <= count + CNT_ONE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      width  <= '0;
      period <= '0;
    end else begin
      if (strb.capWidth)  width  <= count;
      if (strb.capPeriod) period <= count;
    end
  end

endmodule

// File: rtl/pct_control.sv
module pct_control
  import pct_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              riseEdge,
  input  logic              fallEdge,
  input  logic              atMax,
  output strobe_t           strb,
  output logic              enable,
  output logic              startOnRise,
  output logic              irqOnPeriod,
  output logic              irqEn,
  output logic              irqFlag,
  output logic              ovfFlag
);

  localparam logic [ADDR_W-1:0] ADR_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADR_STAT = ADDR_W'(1);

  phase_t  phase, phaseNext;
  strobe_t strbNext;
  logic    startEdge, midEdge;
  logic    ctrlWr, statWr, clrIrq, clrOvf, setIrq;
  logic    unusedWrBits;

  assign unusedWrBits = ^wrData[DATA_W-1:4];

  assign startEdge = startOnRise ? riseEdge : fallEdge;
  assign midEdge   = startOnRise ? fallEdge : riseEdge;

  // Sequencer: decides each cycle what the datapath does
  always_comb begin
    strbNext  = '0;
    phaseNext = phase;
    if (!enable) begin
      phaseNext = PH_IDLE;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          if (startEdge) begin
            strbNext.loadOne = 1'b1;
            phaseNext        = PH_FIRST;
          end
        end
        PH_FIRST: begin
          if (atMax) begin
            strbNext.overflow = 1'b1;
            phaseNext         = PH_IDLE;
          end else begin
            strbNext.incr = 1'b1;
            if (midEdge) begin
              strbNext.capWidth = 1'b1;
              phaseNext         = PH_SECOND;
            end
          end
        end
        PH_SECOND: begin
          if (atMax) begin
            strbNext.overflow = 1'b1;
            phaseNext         = PH_IDLE;
          end else if (startEdge) begin
            strbNext.capPeriod = 1'b1;
            strbNext.loadOne   = 1'b1;
            phaseNext          = PH_FIRST;
          end else begin
            strbNext.incr = 1'b1;
          end
        end
        default: phaseNext = PH_IDLE;
      endcase
    end
  end

  assign strb = strbNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= PH_IDLE;
    else       phase <= phaseNext;
  end

  // Control fields; a hardware stop on overflow beats a same-cycle write
  assign ctrlWr = wrEn && (regAddr == ADR_CTRL);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enable      <= 1'b0;
      startOnRise <= 1'b0;
      irqOnPeriod <= 1'b0;
      irqEn       <= 1'b0;
    end else begin
      if (ctrlWr) begin
        enable      <= wrData[0];
        startOnRise <= wrData[1];
        irqOnPeriod <= wrData[2];
        irqEn       <= wrData[3];
      end
      if (strb.overflow) enable <= 1'b0;
    end
  end

  // Sticky flags, write-one-to-clear, set has priority
  assign statWr = wrEn && (regAddr == ADR_STAT);
  assign clrIrq = statWr && wrData[0];
  assign clrOvf = statWr && wrData[1];
  assign setIrq = (strb.capWidth && !irqOnPeriod) ||
                  (strb.capPeriod && irqOnPeriod) ||
                  (strb.overflow && irqEn);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqFlag <= 1'b0;
      ovfFlag <= 1'b0;
    end else begin
      irqFlag <= setIrq        | (irqFlag & ~clrIrq);
      ovfFlag <= strb.overflow | (ovfFlag & ~clrOvf);
    end
  end

endmodule

// File: rtl/pulse_capture_timer.sv
module pulse_capture_timer
  import pct_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pinIn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [CNT_W-1:0]  wrData,
  output logic [CNT_W-1:0]  rdData,
  output logic              irq
);

  localparam logic [ADDR_W-1:0] ADR_CTRL  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADR_STAT  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] ADR_WIDTH = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] ADR_PRD   = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] ADR_COUNT = ADDR_W'(4);

  strobe_t          strb;
  logic             riseEdge, fallEdge, atMax;
  logic             enable, startOnRise, irqOnPeriod, irqEn;
  logic             irqFlag, ovfFlag;
  logic [CNT_W-1:0] count, width, period;

  pct_control #(
    .ADDR_W (ADDR_W),
    .DATA_W (CNT_W)
  ) u_ctl (
    .clk         (clk),
    .rstN        (rstN),
    .wrEn        (wrEn),
    .regAddr     (regAddr),
    .wrData      (wrData),
    .riseEdge    (riseEdge),
    .fallEdge    (fallEdge),
    .atMax       (atMax),
    .strb        (strb),
    .enable      (enable),
    .startOnRise (startOnRise),
    .irqOnPeriod (irqOnPeriod),
    .irqEn       (irqEn),
    .irqFlag     (irqFlag),
    .ovfFlag     (ovfFlag)
  );

  pct_datapath #(
    .CNT_W       (CNT_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .pinIn    (pinIn),
    .strb     (strb),
    .riseEdge (riseEdge),
    .fallEdge (fallEdge),
    .atMax    (atMax),
    .count    (count),
    .width    (width),
    .period   (period)
  );

  always_comb begin
    unique case (regAddr)
      ADR_CTRL:  rdData = CNT_W'({irqEn, irqOnPeriod, startOnRise, enable});
      ADR_STAT:  rdData = CNT_W'({ovfFlag, irqFlag});
      ADR_WIDTH: rdData = width;
      ADR_PRD:   rdData = period;
      ADR_COUNT: rdData = count;
      default:   rdData = '0;
    endcase
  end

  assign irq = irqFlag & irqEn;

endmodule

// File: rtl/pct_checker.sv
module pct_checker
  import pct_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [CNT_W-1:0]  wrData,
  input logic              irq,
  input strobe_t           strb,
  input logic              enable,
  input logic              irqEn,
  input logic              irqFlag,
  input logic              ovfFlag,
  input logic [CNT_W-1:0]  count,
  input logic [CNT_W-1:0]  width,
  input logic [CNT_W-1:0]  period
);

  localparam logic [ADDR_W-1:0] ADR_STAT = ADDR_W'(1);
  localparam logic [CNT_W-1:0]  CNT_MAX  = '1;
  localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);

  logic wipeIrq, wipeOvf;
  assign wipeIrq = wrEn && (regAddr == ADR_STAT) && wrData[0];
  assign wipeOvf = wrEn && (regAddr == ADR_STAT) && wrData[1];

  // R7: flags persist until an explicit clear
  p_irq_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    (irqFlag && !wipeIrq) |=> irqFlag);

  p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !wipeOvf) |=> ovfFlag);

  // R7: a set event beats a simultaneous clear
  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.overflow && wipeOvf) |=> ovfFlag);

  // R6: overflow always leaves the timer stopped
  p_ovf_stops_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovfFlag) |-> !enable);

  // R6: the count never wraps past all-ones
  p_no_wrap_r6: assert property (@(posedge clk) disable iff (!rstN)
    (count == CNT_MAX) |=> (count == CNT_MAX || count == CNT_ONE));

  // R9: no request leaves the block with interrupts off
  p_irq_gated_r9: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> irqEn);

  // R8: a stopped timer freezes count and captures
  p_hold_off_r8: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> ($stable(count) && $stable(width) && $stable(period)));

  // R2: one capture kind per clock
  p_one_capture_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.capWidth, strb.capPeriod, strb.overflow}));

endmodule

bind pulse_capture_timer pct_checker #(
  .CNT_W  (CNT_W),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .wrEn    (wrEn),
  .regAddr (regAddr),
  .wrData  (wrData),
  .irq     (irq),
  .strb    (strb),
  .enable  (enable),
  .irqEn   (irqEn),
  .irqFlag (irqFlag),
  .ovfFlag (ovfFlag),
  .count   (count),
  .width   (width),
  .period  (period)
);

// File: tb/pulse_capture_timer_tb.sv
`timescale 1ns/1ps
module pulse_capture_timer_tb;

  localparam int CNT_W  = 10;
  localparam int ADDR_W = 3;
  localparam int MAXV   = (1 << CNT_W) - 1;
  localparam int LAT    = 3;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              pinIn = 1'b1;
  logic              wrEn = 1'b0;
  logic [ADDR_W-1:0] regAddr = '0;
  logic [CNT_W-1:0]  wrData = '0;
  logic [CNT_W-1:0]  rdData;
  logic              irq;

  int total = 0;
  int bad = 0;
  int cycle = 0;

  typedef struct {
    int w;
    int p;
    int c;
  } item_t;
  item_t sbq[$];

  pulse_capture_timer #(
    .CNT_W  (CNT_W),
    .ADDR_W (ADDR_W)
  ) u_dut (
    .clk     (clk),
    .rstN    (rstN),
    .pinIn   (pinIn),
    .wrEn    (wrEn),
    .regAddr (regAddr),
    .wrData  (wrData),
    .rdData  (rdData),
    .irq     (irq)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cycle <= cycle + 1;

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic regWrite(input int addr, input int data);
    @(negedge clk);
    regAddr = addr[ADDR_W-1:0];
    wrData  = data[CNT_W-1:0];
    wrEn    = 1'b1;
    @(negedge clk);
    wrEn    = 1'b0;
  endtask

  task automatic regRead(input int addr, output int val);
    @(negedge clk);
    regAddr = addr[ADDR_W-1:0];
    #1;
    val = int'(rdData);
  endtask

  task automatic doReset(input logic idleLevel);
    pinIn = idleLevel;
    rstN  = 1'b0;
    repeat (3) @(negedge clk);
    rstN  = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  function automatic item_t mk(input int w, input int p);
    item_t it;
    it.w = w;
    it.p = p;
    it.c = cycle;
    return it;
  endfunction

  // Driver: plays phases and pushes what each interrupt should report
  task automatic driveRun(input logic startLvl, input bit perMode,
                          input int a[4], input int b[4], input int n);
    int prevP = 0;
    @(negedge clk);
    for (int i = 0; i < n; i++) begin
      pinIn = startLvl;
      if (perMode && i > 0) sbq.push_back(mk(a[i-1], a[i-1] + b[i-1]));
      repeat (a[i]) @(negedge clk);
      pinIn = ~startLvl;
      if (!perMode) sbq.push_back(mk(a[i], prevP));
      prevP = a[i] + b[i];
      repeat (b[i]) @(negedge clk);
    end
    pinIn = startLvl;
    if (perMode) sbq.push_back(mk(a[n-1], a[n-1] + b[n-1]));
    repeat (20) @(negedge clk);
  endtask

  // Monitor: pops expectations as interrupts appear
  task automatic monitor(input int n, input string req);
    int got = 0;
    int guard = 0;
    int w, p;
    item_t it;
    while (got < n && guard < 5000) begin
      @(negedge clk);
      guard++;
      if (irq) begin
        if (sbq.size() == 0) begin
          check({req, " unexpected irq"}, 1, 0);
        end else begin
          it = sbq.pop_front();
          check({req, " irq latency"}, cycle - it.c, LAT);
          regRead(2, w);
          regRead(3, p);
          check({req, " width"}, w, it.w);
          check({req, " period"}, p, it.p);
        end
        regWrite(1, 1);
        got++;
      end
    end
    check({req, " irq count"}, got, n);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cycle, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int v, w0, p0, c0;
    int aA[4] = '{5, 9, 12, 6};
    int bA[4] = '{7, 6, 12, 20};
    int aB[4] = '{8, 15, 7, 0};
    int bB[4] = '{10, 6, 7, 0};
    int aC[4] = '{6, 11, 20, 0};
    int bC[4] = '{9, 8, 5, 0};

    // R10: reset values
    doReset(1'b1);
    regRead(0, v); check("R10 ctrl reset", v, 0);
    regRead(1, v); check("R10 status reset", v, 0);
    regRead(2, v); check("R10 width reset", v, 0);
    regRead(3, v); check("R10 period reset", v, 0);
    regRead(4, v); check("R10 count reset", v, 0);
    regRead(5, v); check("R10 unmapped", v, 0);
    check("R9 irq reset", int'(irq), 0);

    // R1 R2 R5: fall start, width interrupts, first period reads 0
    regWrite(0, 1 | 8);
    fork
      driveRun(1'b0, 1'b0, aA, bA, 4);
      monitor(4, "R5 R2 R1");
    join
    repeat (10) @(negedge clk);
    check("R5 queue empty", sbq.size(), 0);
    regWrite(0, 0);

    // R2 R4: fall start, period interrupts
    doReset(1'b1);
    regWrite(0, 1 | 4 | 8);
    fork
      driveRun(1'b0, 1'b1, aB, bB, 3);
      monitor(3, "R4 R2");
    join
    check("R4 queue empty", sbq.size(), 0);
    regWrite(0, 0);

    // R3: rise start, period interrupts
    doReset(1'b0);
    regWrite(0, 1 | 2 | 4 | 8);
    fork
      driveRun(1'b1, 1'b1, aC, bC, 3);
      monitor(3, "R3 R4");
    join
    check("R3 queue empty", sbq.size(), 0);

    // R8: disabled timer ignores the pin and holds everything
    regWrite(0, 2 | 4 | 8);
    regRead(4, c0);
    regRead(2, w0);
    regRead(3, p0);
    check("R3 last width", w0, 20);
    check("R3 last period", p0, 25);
    for (int k = 0; k < 4; k++) begin
      pinIn = ~pinIn;
      repeat (6) @(negedge clk);
    end
    pinIn = 1'b0;
    repeat (6) @(negedge clk);
    regRead(4, v); check("R8 count held", v, c0);
    regRead(2, v); check("R8 width held", v, w0);
    regRead(3, v); check("R8 period held", v, p0);
    regWrite(0, 1 | 2 | 4 | 8);
    repeat (10) @(negedge clk);
    regRead(4, v); check("R8 waits for start", v, c0);
    pinIn = 1'b1;
    repeat (9) @(negedge clk);
    regRead(4, v); check("R1 reload then count", v, 8);
    regWrite(0, 0);

    // R6 R7: overflow with interrupts on
    doReset(1'b1);
    regWrite(0, 1 | 8);
    @(negedge clk);
    pinIn = 1'b0;
    repeat (1100) @(negedge clk);
    regRead(1, v); check("R6 status after overflow", v, 3);
    regRead(0, v); check("R6 enable cleared", v, 8);
    regRead(4, v); check("R6 count saturated", v, MAXV);
    check("R6 irq out", int'(irq), 1);
    repeat (40) @(negedge clk);
    regRead(1, v); check("R7 sticky", v, 3);
    regWrite(1, 2);
    regRead(1, v); check("R7 clear ovf only", v, 1);
    check("R7 irq still set", int'(irq), 1);
    regWrite(1, 1);
    regRead(1, v); check("R7 clear irq", v, 0);
    check("R7 irq dropped", int'(irq), 0);

    // R6 R9: overflow with interrupts off
    doReset(1'b1);
    regWrite(0, 1);
    @(negedge clk);
    pinIn = 1'b0;
    repeat (1100) @(negedge clk);
    regRead(1, v); check("R6 ovf without irq flag", v, 2);
    check("R9 irq off", int'(irq), 0);

    // R9: flag raised while masked shows once unmasked
    doReset(1'b1);
    regWrite(0, 1);
    @(negedge clk);
    pinIn = 1'b0;
    repeat (8) @(negedge clk);
    pinIn = 1'b1;
    repeat (10) @(negedge clk);
    regRead(1, v); check("R9 masked flag", v, 1);
    regRead(2, v); check("R1 masked width", v, 8);
    check("R9 masked irq low", int'(irq), 0);
    regWrite(0, 1 | 8);
    @(negedge clk);
    check("R9 unmasked irq", int'(irq), 1);
    regWrite(0, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule